// File: doc/BRIEF.md
# Stochastic Bundle Arithmetic Unit with Operand Rearrangement

This block combines two stochastic bundles of W wires each (64 by default). A bundle carries a value through its count of set wires, c. The signed value is (2c/W) - 1. A value is non-negative when at least half of its wires are set. On a start pulse the unit takes one snapshot of both bundles. In the next cycle it counts the set wires of each snapshot and rebuilds each operand as a contiguous run of ones on a ring of W positions.

The length and the ring offset of each run are chosen from the operation and from the operand signs. For addition and subtraction this makes the per-wire gate (OR or AND) combine the two number parts without interference. Subtraction negates B by packing its count of clear wires in place of its count of set wires. The rebuilt operands then circulate. For addition and subtraction both rings turn one position per cycle together. For multiplication B turns every cycle and A turns once per W cycles, so every pairing of A and B wires meets within W×W cycles. The per-wire gate forms the result bundle, and a second gate flags the wires on which the sum ran out of range.

Typical use: pulse `start` with the operands present, wait for `ready`, then read a space average (addition or subtraction) or a time average over W-cycle blocks (multiplication). W must be an even power of two.

Top module: `sbr_arith_unit`

## Requirements
- R1: During and after reset, before any start, `ready` is 0 and `result` and `ovf` are all zero.
- R2: The edge that samples `start`=1 takes the snapshots and clears `ready`. The following edge sets `ready`. While `ready` is 0, `result` and `ovf` are all zero.
- R3: Operation code 2'b00 (add) and code 2'b11 (treated as add): while ready, the number of set result wires equals ca+cb-W/2, limited to the range 0..W. Here ca and cb are the set-wire counts of the A and B snapshots.
- R4: Operation code 2'b01 (subtract A-B): while ready, the number of set result wires equals ca-cb+W/2, limited to the range 0..W.
- R5: For add and subtract, take cb' as cb (add) or W-cb (subtract). If ca and cb' are both at least W/2, `ovf` has max(0, ca+cb'-3W/2) set wires. If both are below W/2, it has max(0, W/2-ca-cb') set wires. With mixed signs, `ovf` is all zero.
- R6: A count of exactly W/2 counts as non-negative (value zero). For example, adding 32 and 32 gives 32 set wires and no overflow.
- R7: For add and subtract, in each ready cycle with no new start, `result` and `ovf` equal their previous values rotated by one wire toward the higher index, with wire W-1 wrapping to wire 0.
- R8: Operation code 2'b10 (multiply): summed over the first W ready cycles, the set result wires total ca·cb + (W-ca)(W-cb). In multiply mode `ovf` stays all zero.
- R9: In multiply mode, each aligned block of W ready cycles gives the same total as in R8. After W×W ready cycles the result pattern repeats the first ready cycle's pattern.
- R10: Changes to `a_bundle`, `b_bundle` and `op` after the sampling edge do not affect the result.
- R11: A start pulse while `ready` is 1 aborts the current run and processes the new snapshot under the timing of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Take a snapshot of the operands and operation |
| op | input | 2 | 00 add, 01 subtract, 10 multiply, 11 add |
| a_bundle | input | W | Operand bundle A |
| b_bundle | input | W | Operand bundle B |
| result | output | W | Result bundle, zero while not ready |
| ovf | output | W | Per-wire out-of-range flag, zero while not ready |
| ready | output | 1 | Result bundle valid |

## Verification
The hardest situation to reach is the multiply pairing schedule. It only shows after W ready cycles, when the slow ring first advances, and its full period ends after W×W cycles. The multiply scenarios therefore hold one run for 4096 cycles. They sum the result population per aligned 64-cycle block and compare the pattern at the period end with the first one. Out-of-range sums are reached by choosing counts whose effective values cross both rails. Subtraction is included, so that the negated-B path also produces overflow on both sides.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_ALT = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PACK = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        G_OR   = 2'd0,
        G_AND  = 2'd1,
        G_XNOR = 2'd2
    } gate_e;

    typedef enum logic [1:0] {
        OV_NONE      = 2'd0,
        OV_BOTH_ONE  = 2'd1,
        OV_BOTH_ZERO = 2'd2
    } ovk_e;
endpackage

// File: rtl/sbr_popcount.sv
module sbr_popcount #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/sbr_packer.sv
// Builds a run of cnt ones on a ring of W wires, starting at wire off and
// growing toward higher indices with wrap-around.
module sbr_packer #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1),
    parameter int OW = $clog2(W)
) (
    input  logic [CW-1:0] cnt,
    input  logic [OW-1:0] off,
    output logic [W-1:0]  vec
);
    always_comb begin
        for (int i = 0; i < W; i++) begin
            vec[i] = (((i + W - int'(off)) % W) < int'(cnt));
        end
    end
endmodule

// File: rtl/sbr_wire_gate.sv
module sbr_wire_gate
    import sbr_pkg::*;
#(
    parameter int W = 64
) (
    input  gate_e        gate,
    input  ovk_e         ovk,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r,
    output logic [W-1:0] ov
);
    for (genvar i = 0; i < W; i++) begin : g_wire
        assign r[i]  = (gate == G_OR)  ? (a[i] | b[i]) :
                       (gate == G_AND) ? (a[i] & b[i]) :
                                         ~(a[i] ^ b[i]);
        assign ov[i] = (ovk == OV_BOTH_ONE)  ? (a[i] & b[i]) :
                       (ovk == OV_BOTH_ZERO) ? (~a[i] & ~b[i]) :
                                               1'b0;
    end
endmodule

// File: rtl/sbr_arith_unit.sv
module sbr_arith_unit
    import sbr_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] a_bundle,
    input  logic [W-1:0] b_bundle,
    output logic [W-1:0] result,
    output logic [W-1:0] ovf,
    output logic         ready
);
    localparam int HALF = W / 2;
    localparam int CW   = $clog2(W + 1);
    localparam int OW   = $clog2(W);
    localparam logic [W-1:0] LOW_MASK  = {{HALF{1'b0}}, {HALF{1'b1}}};
    localparam logic [W-1:0] HIGH_MASK = ~LOW_MASK;

    typedef struct packed {
        phase_e        ph;
        logic          sub;
        logic          mul;
        gate_e         gate;
        ovk_e          ovk;
        logic [W-1:0]  a_snap;
        logic [W-1:0]  b_snap;
        logic [W-1:0]  a_ring;
        logic [W-1:0]  b_ring;
        logic [OW-1:0] slow;
    } state_t;

    state_t s_d, s_q;

    logic [CW-1:0] cnt_a, cnt_b_raw, cnt_b_eff;
    logic [OW-1:0] off_b;
    logic [W-1:0]  a_pk, b_pk;
    logic          a_pos, b_pos;
    logic [W-1:0]  r_raw, ov_raw;
    logic          mul_mode;

    sbr_popcount #(.W(W), .CW(CW)) pc_a_i (.vec(s_q.a_snap), .cnt(cnt_a));
    sbr_popcount #(.W(W), .CW(CW)) pc_b_i (.vec(s_q.b_snap), .cnt(cnt_b_raw));

    // Subtraction negates B: its clear-wire count becomes the packed length.
    assign cnt_b_eff = s_q.sub ? (CW'(W) - cnt_b_raw) : cnt_b_raw;
    // B run ends at wire HALF-1 for add/sub, starts at wire 0 for multiply.
    assign off_b = s_q.mul ? '0 : OW'((HALF + W - int'(cnt_b_eff)) % W);

    sbr_packer #(.W(W), .CW(CW), .OW(OW)) pk_a_i (.cnt(cnt_a), .off('0), .vec(a_pk));
    sbr_packer #(.W(W), .CW(CW), .OW(OW)) pk_b_i (.cnt(cnt_b_eff), .off(off_b), .vec(b_pk));

    // Bottom-packed A: the middle wire alone tells its sign.
    assign a_pos = a_pk[HALF-1];
    assign b_pos = (int'(cnt_b_eff) >= HALF);

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.ph     = PH_PACK;
            s_d.a_snap = a_bundle;
            s_d.b_snap = b_bundle;
            s_d.sub    = (op_e'(op) == OP_SUB);
            s_d.mul    = (op_e'(op) == OP_MUL);
        end else begin
            unique case (s_q.ph)
                PH_PACK: begin
                    s_d.ph     = PH_RUN;
                    s_d.slow   = '0;
                    s_d.b_ring = b_pk;
                    if (s_q.mul) begin
                        s_d.a_ring = a_pk;
                        s_d.gate   = G_XNOR;
                        s_d.ovk    = OV_NONE;
                    end else begin
                        s_d.a_ring = a_pos ? (a_pk & HIGH_MASK) : (a_pk | HIGH_MASK);
                        s_d.gate   = a_pos ? G_OR : G_AND;
                        if (a_pos && b_pos) begin
                            s_d.ovk = OV_BOTH_ONE;
                        end else if (!a_pos && !b_pos) begin
                            s_d.ovk = OV_BOTH_ZERO;
                        end else begin
                            s_d.ovk = OV_NONE;
                        end
                    end
                end
                PH_RUN: begin
                    s_d.b_ring = {s_q.b_ring[W-2:0], s_q.b_ring[W-1]};
                    if (!s_q.mul || (s_q.slow == OW'(W - 1))) begin
                        s_d.a_ring = {s_q.a_ring[W-2:0], s_q.a_ring[W-1]};
                    end
                    s_d.slow = s_q.slow + OW'(1);
                end
                default: s_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    sbr_wire_gate #(.W(W)) gate_i (
        .gate (s_q.gate),
        .ovk  (s_q.ovk),
        .a    (s_q.a_ring),
        .b    (s_q.b_ring),
        .r    (r_raw),
        .ov   (ov_raw)
    );

    assign ready    = (s_q.ph == PH_RUN);
    assign result   = ready ? r_raw  : '0;
    assign ovf      = ready ? ov_raw : '0;
    assign mul_mode = s_q.mul;
endmodule

// File: rtl/sbr_arith_chk.sv
module sbr_arith_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         ready,
    input logic         mode_mul,
    input logic [W-1:0] result,
    input logic [W-1:0] ovf
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (result == '0 && ovf == '0)); // R2

    AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready); // R2

    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> ready); // R11

    AST_RESULT_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start && !mode_mul) |=>
        (result == {$past(result[W-2:0]), $past(result[W-1])})); // R7

    AST_OVF_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start && !mode_mul) |=>
        (ovf == {$past(ovf[W-2:0]), $past(ovf[W-1])})); // R7

    AST_NO_MUL_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && mode_mul) |-> (ovf == '0)); // R8
endmodule

bind sbr_arith_unit sbr_arith_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ready    (ready),
    .mode_mul (mul_mode),
    .result   (result),
    .ovf      (ovf)
);

// File: tb/sbr_arith_unit_tb_top.sv
module sbr_arith_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op_in = 2'b00;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] result, ovf;
    logic         ready;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sbr_arith_unit #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_in),
        .a_bundle(a_in), .b_bundle(b_in),
        .result(result), .ovf(ovf), .ready(ready)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_vec(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scattered bundle with k set wires (37 is odd, so i*37 mod 64 permutes).
    function automatic logic [W-1:0] mk(input int k, input int seed);
        logic [W-1:0] v = '0;
        for (int i = 0; i < k; i++) v[(i * 37 + seed) % W] = 1'b1;
        return v;
    endfunction

    function automatic int clampi(input int v);
        return (v < 0) ? 0 : ((v > W) ? W : v);
    endfunction

    // Start an operation, then scramble the inputs after the sampling edge.
    task automatic launch(input int ca, input int cb, input logic [1:0] o);
        @(negedge clk);
        a_in  = mk(ca, 3);
        b_in  = mk(cb, 11);
        op_in = o;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 ready low after sampling edge", ready, 0);
        chk_vec("R2 result zero while not ready", result, '0);
        a_in  = ~a_in;     // R10: must not matter
        b_in  = ~b_in;
        op_in = ~o;
        @(negedge clk);
        chk("R2 ready high one edge later", ready, 1);
    endtask

    task automatic test_addsub(input int ca, input int cb, input logic [1:0] o, input string req);
        int cbe, er, eo;
        logic [W-1:0] pr, po;
        cbe = (o == 2'b01) ? (W - cb) : cb;
        er  = clampi(ca + cbe - W / 2);
        if (ca >= W / 2 && cbe >= W / 2)      eo = clampi(ca + cbe - 3 * W / 2);
        else if (ca < W / 2 && cbe < W / 2)   eo = clampi(W / 2 - ca - cbe);
        else                                  eo = 0;
        launch(ca, cb, o);
        chk({req, " R10 result population"}, $countones(result), er);
        chk("R5 overflow population", $countones(ovf), eo);
        for (int k = 0; k < 3; k++) begin
            pr = result;
            po = ovf;
            @(negedge clk);
            chk_vec("R7 result rotation", result, {pr[W-2:0], pr[W-1]});
            chk_vec("R7 overflow rotation", ovf, {po[W-2:0], po[W-1]});
        end
    endtask

    task automatic test_mul(input int ca, input int cb);
        longint f, sum;
        logic [W-1:0] r0;
        int ovf_seen;
        f = longint'(ca) * cb + longint'(W - ca) * (W - cb);
        launch(ca, cb, 2'b10);
        r0 = result;
        sum = 0;
        ovf_seen = 0;
        for (int t = 0; t < W * W; t++) begin
            if (t > 0) @(negedge clk);
            sum += $countones(result);
            if (ovf != '0) ovf_seen++;
            if (t == W - 1)     chk("R8 first block time sum", sum, f);
            if (t == 2 * W - 1) chk("R9 second block time sum", sum, 2 * f);
        end
        chk("R9 full period time sum", sum, longint'(W) * f);
        chk("R8 multiply never flags overflow", ovf_seen, 0);
        @(negedge clk);
        chk_vec("R9 pattern repeats after W*W cycles", result, r0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready low in reset", ready, 0);
        chk_vec("R1 result zero in reset", result, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 ready low after reset", ready, 0);
        chk_vec("R1 ovf zero after reset", ovf, '0);

        test_addsub(40, 45, 2'b00, "R3 add pos+pos");
        test_addsub(60, 50, 2'b00, "R3 add positive overflow");
        test_addsub(10, 12, 2'b00, "R3 add negative overflow");
        test_addsub(20, 20, 2'b00, "R3 add neg+neg");
        test_addsub(10, 50, 2'b00, "R3 add neg+pos");
        test_addsub(50, 10, 2'b00, "R3 add pos+neg");
        test_addsub(32, 32, 2'b00, "R6 zero plus zero");
        test_addsub(32, 0, 2'b00, "R6 zero plus minus one");
        test_addsub(30, 40, 2'b11, "R3 code 11 as add");
        test_addsub(50, 20, 2'b01, "R4 sub pos-neg");
        test_addsub(60, 2, 2'b01, "R4 sub positive overflow");
        test_addsub(5, 60, 2'b01, "R4 sub negative overflow");
        test_addsub(20, 40, 2'b01, "R4 sub neg-pos");
        test_addsub(32, 32, 2'b01, "R6 zero minus zero");

        // R11: abort a running add with a new subtraction
        launch(44, 44, 2'b00);
        repeat (5) @(negedge clk);
        test_addsub(48, 16, 2'b01, "R11 restart while ready");

        test_mul(48, 16);
        test_mul(64, 64);
        test_mul(0, 64);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule